// File: doc/BRIEF.md
# Fractional Sample-Rate Tick Generator

This block turns a master-rate clock-enable stream into a lower sample-rate tick using an error accumulator in the Bresenham style. Two master families arrive as single-cycle enable pulses, one at 44.1 kHz and one at 48 kHz. Each generator picks one family and produces a tick at `master * inc / mod`. With the usual increment of 4, a modulus of `4 * master / rate` gives any sample rate from 8000 to 48000 per second.

The block holds independent generators, one for playback and one for record by default. Each has two write-only control words. The first word picks the master family. The second word packs the increment together with an encoded form of the modulus, so the modulus is never stored as written. Software picks the family whose master rate leaves the smaller remainder when divided by the target rate. Any write to a generator restarts its accumulator from zero, which gives a known phase whenever the generator is set up again.

Top module: `frac_rate_gen`

## Requirements
- R1: After reset every tick output is 0 and stays 0 under any master pulses until a generator is programmed. The reset values are: master select 0, control word 2 zero, and accumulator zero.
- R2: Writing control word 1 (`wr_addr_i`=0) sets the master select from bit 0 of the data. A 1 makes the generator count `ce_441_i` pulses, and a 0 makes it count `ce_48_i` pulses. Pulses on the source that is not selected have no effect.
- R3: Writing control word 2 (`wr_addr_i`=1) sets the increment from data bits 15:0. Data bits 31:16 hold `(inc - mod - 1) mod 2^16`, and the modulus is recovered from them as `mod = inc - 1 - field` in 16-bit arithmetic.
- R4: On each selected master pulse the accumulator grows by `inc`. When the sum is `mod` or more, `mod` is taken off the sum and the tick output is high for exactly the one cycle after the pulse. Otherwise the tick is low in that cycle.
- R5: Starting from a cleared accumulator, N selected pulses produce exactly `floor(N * inc / mod)` ticks.
- R6: A write to either control word of a generator clears its accumulator. A master pulse in the same cycle as the write is discarded, and no tick follows it.
- R7: A modulus of zero, or a modulus below `inc`, suppresses all ticks from that generator.
- R8: `wr_gen_i` selects which generator a write goes to. A generator that is not addressed keeps its settings, its accumulator phase and its tick sequence.
- R9: Bits 31:1 of control word 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_441_i | input | 1 | 44.1 kHz master clock-enable pulse |
| ce_48_i | input | 1 | 48 kHz master clock-enable pulse |
| wr_en_i | input | 1 | Control write strobe |
| wr_gen_i | input | GEN_W | Generator addressed by the write |
| wr_addr_i | input | 1 | 0 = control word 1, 1 = control word 2 |
| wr_data_i | input | 32 | Write data |
| tick_o | output | NUM_GEN | Sample-rate tick, one bit per generator |

## Verification
A wrong accumulator value shows up at the tick outputs as a tick that comes too early or too late. Because each pulse is compared cycle by cycle against a model, the error is seen at the first crossing that is out of place, at most `mod / inc` pulses later. A wrongly recovered modulus or a swapped master select changes the spacing between ticks at once. Long runs of pulses with a tick count checked at the end catch slow drift in the rate. A write that fails to clear the accumulator shifts the phase of the next tick, and a write that reaches the wrong generator disturbs the sequence of the other generator.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  localparam int CTRL_W = 32;
  localparam int INC_W  = 16;

  typedef enum logic {
    MSTR_48K = 1'b0,
    MSTR_44K = 1'b1
  } mstr_sel_e;

  typedef enum logic {
    REG_SRC  = 1'b0,
    REG_STEP = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/frac_rate_regs.sv
module frac_rate_regs
  import frac_rate_pkg::*;
#(
  parameter int W = INC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [CTRL_W-1:0] data_i,
  output mstr_sel_e         sel_o,
  output logic [W-1:0]      inc_o,
  output logic [W-1:0]      mod_o,
  output logic              valid_o
);
  logic [W-1:0] inc_q, fld_q;
  mstr_sel_e    sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= MSTR_48K;
      inc_q <= '0;
      fld_q <= '0;
    end else if (wr_i) begin
      if (addr_i == REG_SRC) begin
        sel_q <= mstr_sel_e'(data_i[0]);
      end else begin
        inc_q <= data_i[W-1:0];
        fld_q <= data_i[2*W-1:W];
      end
    end
  end

  // modulus is carried as (inc - mod - 1)
  assign mod_o   = inc_q - W'(1) - fld_q;
  assign inc_o   = inc_q;
  assign sel_o   = sel_q;
  assign valid_o = (mod_o != '0) && (mod_o >= inc_q);
endmodule

// File: rtl/frac_rate_accum.sv
module frac_rate_accum
  import frac_rate_pkg::*;
#(
  parameter int W = INC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         pulse_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  input  logic         valid_i,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum, diff;
  logic         tick_q;

  assign sum  = {1'b0, acc_q} + {1'b0, inc_i};
  assign diff = sum - {1'b0, mod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (clear_i) begin
        acc_q <= '0;
      end else if (pulse_i && valid_i) begin
        if (sum >= {1'b0, mod_i}) begin
          acc_q  <= diff[W-1:0];
          tick_q <= 1'b1;
        end else begin
          acc_q <= sum[W-1:0];
        end
      end
    end
  end

  assign tick_o = tick_q;

  a_r4_acc_below_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (acc_q < mod_i));

  a_r6_clear_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_q == '0) && !tick_q);

  a_r7_no_tick_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !tick_q);
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import frac_rate_pkg::*;
#(
  parameter int NUM_GEN = 2,
  parameter int GEN_W   = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_441_i,
  input  logic              ce_48_i,
  input  logic              wr_en_i,
  input  logic [GEN_W-1:0]  wr_gen_i,
  input  logic              wr_addr_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [NUM_GEN-1:0] tick_o
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic            hit, pulse, valid;
    mstr_sel_e       sel;
    logic [INC_W-1:0] inc, modv;

    assign hit = wr_en_i && (wr_gen_i == GEN_W'(g));

    frac_rate_regs #(.W(INC_W)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (hit),
      .addr_i  (wr_addr_i),
      .data_i  (wr_data_i),
      .sel_o   (sel),
      .inc_o   (inc),
      .mod_o   (modv),
      .valid_o (valid)
    );

    assign pulse = (sel == MSTR_44K) ? ce_441_i : ce_48_i;

    frac_rate_accum #(.W(INC_W)) u_accum (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (hit),
      .pulse_i (pulse),
      .inc_i   (inc),
      .mod_i   (modv),
      .valid_i (valid),
      .tick_o  (tick_o[g])
    );

    a_r2_tick_from_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o[g] |-> $past(pulse));
  end
endmodule

// File: tb/frac_rate_gen_tb.sv
`timescale 1ns/1ps
module frac_rate_gen_tb;
  localparam int NG = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_441 = 1'b0, ce_48 = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_gen = '0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [NG-1:0] tick;

  always #2.5 clk = ~clk;

  frac_rate_gen #(.NUM_GEN(NG)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_441_i(ce_441), .ce_48_i(ce_48),
    .wr_en_i(wr_en), .wr_gen_i(wr_gen), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_o(tick)
  );

  typedef struct {
    logic [NG-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  int tick_cnt[NG];

  // reference model state
  int m_acc[NG], m_inc[NG], m_mod[NG];
  bit m_sel[NG];
  int p_inc, p_mod;

  task automatic chk(input logic [NG-1:0] act, input logic [NG-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: tick actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit c44, input bit c48, input bit we, input int gen,
                      input bit addr, input logic [31:0] data, input string tag);
    item_t it;
    @(negedge clk);
    ce_441 = c44; ce_48 = c48; wr_en = we; wr_gen = gen[0:0];
    wr_addr = addr; wr_data = data;
    it.tag = tag;
    for (int g = 0; g < NG; g++) begin
      bit pl;
      it.exp[g] = 1'b0;
      if (we && gen == g) begin
        m_acc[g] = 0;
        if (!addr) m_sel[g] = data[0];
        else begin m_inc[g] = p_inc; m_mod[g] = p_mod; end
      end else begin
        pl = m_sel[g] ? c44 : c48;
        if (pl && m_mod[g] != 0 && m_mod[g] >= m_inc[g]) begin
          m_acc[g] += m_inc[g];
          if (m_acc[g] >= m_mod[g]) begin
            m_acc[g] -= m_mod[g];
            it.exp[g] = 1'b1;
          end
        end
      end
    end
    q.push_back(it);
  endtask

  task automatic set_src(input int gen, input logic [31:0] data, input string tag);
    step(0, 0, 1, gen, 0, data, tag);
  endtask

  task automatic set_step(input int gen, input int inc, input int md, input string tag);
    logic [15:0] fld;
    fld = 16'(inc - md - 1);
    p_inc = inc; p_mod = md;
    step(0, 0, 1, gen, 1, {fld, 16'(inc)}, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic drain();
    idle(1, "drain");
    @(posedge clk); #2;
  endtask

  task automatic clr_cnt();
    for (int g = 0; g < NG; g++) tick_cnt[g] = 0;
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(tick, it.exp, it.tag);
        for (int g = 0; g < NG; g++) tick_cnt[g] += int'(tick[g]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_acc[g] = 0; m_inc[g] = 0; m_mod[g] = 65535; m_sel[g] = 0;
    end
    repeat (3) @(negedge clk);
    chk(tick, '0, "R1 in reset");
    rst_n = 1'b1;
    // R1: unprogrammed generators stay quiet
    for (int i = 0; i < 8; i++) step(1, 1, 0, 0, 0, '0, "R1");

    // program gen0: 48k, rate 9600 ; gen1: 44.1k, rate 16036
    set_src(0, 32'h0, "R2");
    set_step(0, 4, 20, "R3");
    set_src(1, 32'h1, "R2");
    set_step(1, 4, 11, "R3");

    // R4: both sources with different cadence
    for (int i = 0; i < 60; i++) step((i % 3) == 0, 1, 0, 0, 0, '0, "R4");

    // R5: rate count from a cleared accumulator
    set_step(0, 4, 20, "R5");
    set_step(1, 4, 11, "R5");
    drain(); clr_cnt();
    for (int i = 0; i < 100; i++) step(i < 44, 1, 0, 0, 0, '0, "R5");
    drain();
    n_chk++;
    if (tick_cnt[0] != 20) begin n_fail++;
      $display("FAIL R5 gen0 ticks actual=%0d expected=20", tick_cnt[0]); end
    n_chk++;
    if (tick_cnt[1] != 16) begin n_fail++;
      $display("FAIL R5 gen1 ticks actual=%0d expected=16", tick_cnt[1]); end

    // R2: gen0 moved to 44.1k, only 48k pulses given -> silent
    set_src(0, 32'h1, "R2");
    for (int i = 0; i < 30; i++) step(0, 1, 0, 0, 0, '0, "R2 unselected");
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 0, '0, "R2 selected");

    // R6: write mid-count with a pulse in the same cycle
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 0, '0, "R6");
    step(1, 1, 1, 0, 0, 32'h1, "R6 write cycle");
    for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0, '0, "R6 after");

    // R8: writes to gen1 while gen0 counts
    for (int i = 0; i < 20; i++) begin
      if (i % 7 == 3) step(1, 1, 1, 1, 0, 32'h1, "R8");
      else            step(1, 1, 0, 0, 0, '0, "R8");
    end

    // R9: upper bits of word 1 ignored -> gen1 on 48k
    set_src(1, 32'hFFFF_FFFE, "R9");
    for (int i = 0; i < 30; i++) step(1, (i % 2) == 0, 0, 0, 0, '0, "R9");

    // R7: suppressed moduli
    set_step(0, 4, 3, "R7");
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, '0, "R7 mod<inc");
    set_step(0, 4, 0, "R7");
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, '0, "R7 mod=0");
    set_step(0, 0, 0, "R7");
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, '0, "R7 inc=0");

    // R4 boundary: mod == inc ticks on every pulse
    set_step(0, 4, 4, "R4");
    for (int i = 0; i < 12; i++) step(i != 5, 0, 0, 0, 0, '0, "R4 mod=inc");

    // R3: larger field values
    set_step(0, 147, 160, "R3");
    set_step(1, 1000, 48000, "R3");
    for (int i = 0; i < 400; i++) step(1, 1, 0, 0, 0, '0, "R3");

    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule